// File: doc/BRIEF.md
# Width-Aware SPI Transmit/Receive FIFO Pair

This block holds the two data queues that sit between the register interface of an SPI controller and its serial shift engine. Each direction owns sixteen bytes of storage. The selected word width decides how those bytes are grouped: sixteen one-byte entries, eight two-byte entries or four four-byte entries. Software pushes transmit words and pops receive words. The shift engine pops transmit words and pushes receive words.

Both fill levels are visible as counts. Two level-based interrupt requests, one per direction, each compare the current fill against one of four selectable conditions. Two sticky error flags record a receive overflow and a transmit underrun. Software clears them with write-one-to-clear strobes, and each has its own enable into a shared fault request. A change of word width, or dropping the enable, empties both queues at once.

Top module: `spi_fifo_pair`

## Requirements
- R1: Width code 0 gives 16 entries of 8 bits, code 1 gives 8 entries of 16 bits, and codes 2 and 3 give 4 entries of 32 bits. A push into a full queue is dropped and leaves the level unchanged.
- R2: A pushed word keeps only its low 8, 16 or 32 bits according to the width. Popped data is zero-extended to 32 bits and comes out in push order.
- R3: Each level is a 5-bit count. It changes on the clock edge that accepts a push or a pop. A push and a pop on the same edge leave it unchanged.
- R4: `rx_empty` is 1 exactly when the receive level is zero.
- R5: Receive interrupt select: 0 fires on level zero, 1 fires on level non-zero, 2 fires on level at least half the entry count, 3 fires on level equal to the entry count.
- R6: Transmit interrupt select: 0 fires on level zero while `eng_tx_busy` is 0, 1 fires on level zero, 2 fires on level at most half the entry count, 3 fires on level below the entry count.
- R7: An engine push into a full receive queue is discarded and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed.
- R8: An engine pop from an empty transmit queue sets `unf_flag`. The flag stays set until `unf_clr` is pulsed. While the transmit queue is empty, `eng_tx_data` is zero.
- R9: `fault_irq` is high when (`ovf_flag` and `ovf_fault_en`) or (`unf_flag` and `unf_fault_en`).
- R10: A change of `width_sel`, or `enable` low, empties both queues on the next edge. It leaves both error flags unchanged.
- R11: A register pop from an empty receive queue has no effect. While the receive queue is empty, `rx_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| width_sel | input | 2 | Word width code (0: 8, 1: 16, 2/3: 32 bits) |
| tx_push | input | 1 | Register-side write into transmit queue |
| tx_wdata | input | 32 | Register-side transmit word |
| rx_pop | input | 1 | Register-side read from receive queue |
| rx_rdata | output | 32 | Head of receive queue, zero when empty |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 32 | Head of transmit queue, zero when empty |
| eng_tx_busy | input | 1 | Engine still shifting a word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word from the engine |
| rx_irq_sel | input | 2 | Receive interrupt condition code |
| tx_irq_sel | input | 2 | Transmit interrupt condition code |
| tx_level | output | 5 | Transmit fill count |
| rx_level | output | 5 | Receive fill count |
| rx_empty | output | 1 | Receive queue empty |
| ovf_clr | input | 1 | Write-one clear for overflow flag |
| unf_clr | input | 1 | Write-one clear for underrun flag |
| ovf_fault_en | input | 1 | Routes overflow flag to fault request |
| unf_fault_en | input | 1 | Routes underrun flag to fault request |
| ovf_flag | output | 1 | Sticky receive overflow |
| unf_flag | output | 1 | Sticky transmit underrun |
| rx_irq | output | 1 | Receive level interrupt request |
| tx_irq | output | 1 | Transmit level interrupt request |
| fault_irq | output | 1 | Combined error interrupt request |

## Verification
Both interrupt lines and `rx_empty` are decoded from the registered levels with no extra stage. A wrong level count therefore shows up on the level ports and on the interrupt pins in the cycle right after the edge that went wrong. A pointer that drifts from the level, or a wrong byte stride, shows in the head data at once. It shows as wrong bytes or wrong order on the next pop, even while the levels still look correct. A flush or flag path that misbehaves shows on the edge after the width change, enable drop or clear strobe. The bench checks one edge after each stimulus.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int STORE_BYTES = 16;
  localparam int LVL_W       = $clog2(STORE_BYTES) + 1;
  localparam int WORD_W      = 32;

  // bytes per entry for a width code
  function automatic logic [2:0] entry_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // entries that fit into the fixed byte store for a width code
  function automatic logic [LVL_W-1:0] entry_cap(input logic [1:0] wcode);
    logic [LVL_W-1:0] full_store;
    full_store = LVL_W'(STORE_BYTES);
    case (wcode)
      2'd0:    return full_store;
      2'd1:    return full_store >> 1;
      default: return full_store >> 2;
    endcase
  endfunction

  function automatic logic rx_trigger(input logic [1:0] sel,
                                      input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] cap);
    case (sel)
      2'd0:    return lvl == '0;
      2'd1:    return lvl != '0;
      2'd2:    return lvl >= (cap >> 1);
      default: return lvl == cap;
    endcase
  endfunction

  function automatic logic tx_trigger(input logic [1:0] sel,
                                      input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] cap,
                                      input logic busy);
    case (sel)
      2'd0:    return (lvl == '0) && !busy;
      2'd1:    return lvl == '0;
      2'd2:    return lvl <= (cap >> 1);
      default: return lvl < cap;
    endcase
  endfunction

endpackage

// File: rtl/spi_fifo_store.sv
module spi_fifo_store
  import spi_fifo_pkg::*;
#(
  parameter int BYTES = STORE_BYTES,
  parameter int LW    = LVL_W,
  parameter int WW    = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [2:0]    ebytes,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [WW-1:0] wdata,
  input  logic          pop,
  output logic [WW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);

  localparam int PTR_W = $clog2(BYTES);
  localparam int LANES = WW / 8;

  logic [7:0]       mem [BYTES];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] stride;

  assign full      = level >= cap;
  assign empty     = level == '0;
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign pop_miss  = pop && empty && !flush;
  assign stride    = PTR_W'(ebytes);

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (push_ok && (k < int'(ebytes)))
        mem[wr_ptr + PTR_W'(k)] <= wdata[8*k +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!empty && (k < int'(ebytes)))
        rdata[8*k +: 8] = mem[rd_ptr + PTR_W'(k)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + stride;
      if (pop_ok)  rd_ptr <= rd_ptr + stride;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap) else $error("level above capacity"); // R1

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop && !pop |=> $stable(level)) else $error("dropped push moved level"); // R1

  AST_PUSH_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok |=> $stable(level)) else $error("push+pop moved level"); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0) else $error("flush left entries"); // R10

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] cap,
  input  logic          busy,
  output logic          rx_req,
  output logic          tx_req
);

  assign rx_req = rx_trigger(rx_sel, rx_lvl, cap);
  assign tx_req = tx_trigger(tx_sel, tx_lvl, cap, busy);

  AST_RX_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req && rx_sel != 2'd0 |-> rx_lvl != '0) else $error("rx irq with no data"); // R5

  AST_TX_EMPTY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl == '0 && tx_sel != 2'd0 |-> tx_req) else $error("empty tx without irq"); // R6

  AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl == cap |-> !tx_req) else $error("full tx raised irq"); // R6

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int SB = STORE_BYTES,
  parameter int LW = $clog2(SB) + 1,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    width_sel,
  input  logic          tx_push,
  input  logic [WW-1:0] tx_wdata,
  input  logic          rx_pop,
  output logic [WW-1:0] rx_rdata,
  input  logic          eng_tx_pop,
  output logic [WW-1:0] eng_tx_data,
  input  logic          eng_tx_busy,
  input  logic          eng_rx_push,
  input  logic [WW-1:0] eng_rx_data,
  input  logic [1:0]    rx_irq_sel,
  input  logic [1:0]    tx_irq_sel,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          rx_empty,
  input  logic          ovf_clr,
  input  logic          unf_clr,
  input  logic          ovf_fault_en,
  input  logic          unf_fault_en,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          fault_irq
);

  logic [1:0]    width_q;
  logic          flush;
  logic [2:0]    ebytes;
  logic [LW-1:0] cap_q;
  logic          tx_full, tx_empty, rx_full;
  logic          tx_push_drop, tx_pop_miss;
  logic          rx_push_drop, rx_pop_miss;

  assign flush  = !enable || (width_sel != width_q);
  assign ebytes = entry_bytes(width_q);
  assign cap_q  = LW'(entry_cap(width_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= 2'd0;
    else        width_q <= width_sel;
  end

  spi_fifo_store #(.BYTES(SB), .LW(LW), .WW(WW)) u_tx_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ebytes(ebytes), .cap(cap_q),
    .push(tx_push), .wdata(tx_wdata), .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_push_drop), .pop_miss(tx_pop_miss)
  );

  spi_fifo_store #(.BYTES(SB), .LW(LW), .WW(WW)) u_rx_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ebytes(ebytes), .cap(cap_q),
    .push(eng_rx_push), .wdata(eng_rx_data), .pop(rx_pop), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_push_drop), .pop_miss(rx_pop_miss)
  );

  spi_fifo_irq #(.LW(LW)) u_irq (
    .clk(clk), .rst_n(rst_n), .rx_sel(rx_irq_sel), .tx_sel(tx_irq_sel),
    .rx_lvl(rx_level), .tx_lvl(tx_level), .cap(cap_q), .busy(eng_tx_busy),
    .rx_req(rx_irq), .tx_req(tx_irq)
  );

  // sticky error flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag && !ovf_clr) || rx_push_drop;
      unf_flag <= (unf_flag && !unf_clr) || tx_pop_miss;
    end
  end

  assign fault_irq = (ovf_flag && ovf_fault_en) || (unf_flag && unf_fault_en);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag) else $error("overflow flag lost"); // R7

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_drop |-> rx_full) else $error("rx drop while not full"); // R7

  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_flag) |-> $past(eng_tx_pop) && $past(tx_empty)) else $error("underrun without empty pop"); // R8

  AST_TX_DROP_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_drop |-> tx_full && tx_level == cap_q) else $error("tx drop below cap"); // R1

  AST_RX_MISS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_miss && !eng_rx_push |=> rx_level == '0) else $error("empty pop changed level"); // R11

  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> ovf_flag || unf_flag) else $error("fault without flag"); // R9

endmodule

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic        tx_push = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        rx_pop = 1'b0;
  logic [31:0] rx_rdata;
  logic        eng_tx_pop = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_tx_busy = 1'b0;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic [1:0]  rx_irq_sel = 2'd0;
  logic [1:0]  tx_irq_sel = 2'd0;
  logic [4:0]  tx_level, rx_level;
  logic        rx_empty;
  logic        ovf_clr = 1'b0, unf_clr = 1'b0;
  logic        ovf_fault_en = 1'b0, unf_fault_en = 1'b0;
  logic        ovf_flag, unf_flag, rx_irq, tx_irq, fault_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  spi_fifo_pair i_spi_fifo_pair (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_sel(width_sel),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_busy(eng_tx_busy),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .rx_irq_sel(rx_irq_sel), .tx_irq_sel(tx_irq_sel),
    .tx_level(tx_level), .rx_level(rx_level), .rx_empty(rx_empty),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr),
    .ovf_fault_en(ovf_fault_en), .unf_fault_en(unf_fault_en),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .fault_irq(fault_irq)
  );

  // {width, pushes, expected level, rx irq mask by sel, tx irq mask by sel}
  localparam logic [19:0] VEC [10] = '{
    {2'd0, 5'd0,  5'd0,  4'b0001, 4'b1111},
    {2'd0, 5'd8,  5'd8,  4'b0110, 4'b1100},
    {2'd0, 5'd16, 5'd16, 4'b1110, 4'b0000},
    {2'd0, 5'd20, 5'd16, 4'b1110, 4'b0000},
    {2'd1, 5'd3,  5'd3,  4'b0010, 4'b1100},
    {2'd1, 5'd4,  5'd4,  4'b0110, 4'b1100},
    {2'd1, 5'd5,  5'd5,  4'b0110, 4'b1000},
    {2'd2, 5'd1,  5'd1,  4'b0010, 4'b1100},
    {2'd2, 5'd4,  5'd4,  4'b1110, 4'b0000},
    {2'd3, 5'd2,  5'd2,  4'b0110, 4'b1100}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_in(input logic [31:0] d);
    eng_rx_push = 1'b1; eng_rx_data = d;
    step();
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_in(input logic [31:0] d);
    tx_push = 1'b1; tx_wdata = d;
    step();
    tx_push = 1'b0;
  endtask

  task automatic regrow(input logic [1:0] w);
    enable = 1'b0; width_sel = w; ovf_clr = 1'b1; unf_clr = 1'b1;
    step();
    enable = 1'b1; ovf_clr = 1'b0; unf_clr = 1'b0;
    step();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    // reset state (R3, R4, R11)
    chk("R3 reset tx_level", 32'(tx_level), 32'd0);
    chk("R3 reset rx_level", 32'(rx_level), 32'd0);
    chk("R4 reset rx_empty", 32'(rx_empty), 32'd1);
    chk("R11 reset rx_rdata", rx_rdata, 32'd0);
    chk("R7 reset ovf", 32'(ovf_flag), 32'd0);
    chk("R8 reset unf", 32'(unf_flag), 32'd0);

    // table walk: capacity, levels and interrupt conditions (R1, R3, R4, R5, R6, R7)
    foreach (VEC[i]) begin
      logic [1:0] w;
      logic [4:0] n, lvl, cap;
      logic [3:0] rxm, txm;
      {w, n, lvl, rxm, txm} = VEC[i];
      cap = 5'd16 >> ((w == 2'd3) ? 2 : w);
      regrow(w);
      if (n != 0) begin
        tx_push = 1'b1; eng_rx_push = 1'b1;
        for (int k = 0; k < int'(n); k++) begin
          tx_wdata = 32'(k); eng_rx_data = 32'(k + 100);
          step();
        end
        tx_push = 1'b0; eng_rx_push = 1'b0;
      end
      chk("R1 table rx level", 32'(rx_level), 32'(lvl));
      chk("R3 table tx level", 32'(tx_level), 32'(lvl));
      chk("R4 table rx_empty", 32'(rx_empty), 32'(lvl == 0));
      chk("R7 table overflow", 32'(ovf_flag), 32'(n > cap));
      for (int s = 0; s < 4; s++) begin
        rx_irq_sel = 2'(s); tx_irq_sel = 2'(s);
        #1;
        chk("R5 table rx irq", 32'(rx_irq), 32'(rxm[s]));
        chk("R6 table tx irq", 32'(tx_irq), 32'(txm[s]));
      end
    end

    // R2 16-bit packing and order on transmit side
    regrow(2'd1);
    tx_in(32'h1234ABCD);
    tx_in(32'hFFFF5678);
    chk("R2 tx head truncated", eng_tx_data, 32'h0000ABCD);
    eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
    chk("R2 tx second word", eng_tx_data, 32'h00005678);
    chk("R3 tx level after pop", 32'(tx_level), 32'd1);
    eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
    chk("R8 tx data zero when empty", eng_tx_data, 32'd0);
    chk("R8 no underrun on valid pop", 32'(unf_flag), 32'd0);

    // R8, R9 underrun and fault routing
    eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
    chk("R8 underrun set", 32'(unf_flag), 32'd1);
    chk("R9 fault masked", 32'(fault_irq), 32'd0);
    unf_fault_en = 1'b1; #1;
    chk("R9 fault on underrun", 32'(fault_irq), 32'd1);
    step();
    chk("R8 underrun sticky", 32'(unf_flag), 32'd1);
    unf_clr = 1'b1; step(); unf_clr = 1'b0;
    chk("R8 underrun cleared", 32'(unf_flag), 32'd0);
    chk("R9 fault drops", 32'(fault_irq), 32'd0);
    unf_fault_en = 1'b0;

    // R2, R3, R11 32-bit receive path
    regrow(2'd2);
    rx_in(32'hDEADBEEF);
    rx_in(32'h01020304);
    chk("R2 rx head word", rx_rdata, 32'hDEADBEEF);
    chk("R4 rx not empty", 32'(rx_empty), 32'd0);
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    chk("R2 rx second word", rx_rdata, 32'h01020304);
    rx_pop = 1'b1; eng_rx_push = 1'b1; eng_rx_data = 32'h000000AA;
    step();
    rx_pop = 1'b0; eng_rx_push = 1'b0;
    chk("R3 push+pop level", 32'(rx_level), 32'd1);
    chk("R2 rx after push+pop", rx_rdata, 32'h000000AA);
    rx_pop = 1'b1; step();
    step(); rx_pop = 1'b0;
    chk("R11 empty pop level", 32'(rx_level), 32'd0);
    chk("R11 empty rdata", rx_rdata, 32'd0);

    // R7 overflow discards the extra word, flag sticky through pops
    rx_in(32'd1); rx_in(32'd2); rx_in(32'd3); rx_in(32'd4);
    rx_in(32'h55);
    chk("R7 overflow set", 32'(ovf_flag), 32'd1);
    chk("R7 level held at cap", 32'(rx_level), 32'd4);
    rx_pop = 1'b1; step(); step(); step(); rx_pop = 1'b0;
    chk("R7 last word not overwritten", rx_rdata, 32'd4);
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    chk("R7 nothing after discard", 32'(rx_level), 32'd0);
    chk("R7 flag survives pops", 32'(ovf_flag), 32'd1);
    ovf_fault_en = 1'b1; #1;
    chk("R9 fault on overflow", 32'(fault_irq), 32'd1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R7 overflow cleared", 32'(ovf_flag), 32'd0);
    ovf_fault_en = 1'b0;

    // R2 8-bit truncation
    regrow(2'd0);
    rx_in(32'h000001FF);
    chk("R2 byte truncation", rx_rdata, 32'h000000FF);

    // R6 engine busy gates select 0
    regrow(2'd0);
    eng_tx_busy = 1'b1; tx_irq_sel = 2'd0; #1;
    chk("R6 sel0 busy", 32'(tx_irq), 32'd0);
    tx_irq_sel = 2'd1; #1;
    chk("R6 sel1 busy", 32'(tx_irq), 32'd1);
    eng_tx_busy = 1'b0; tx_irq_sel = 2'd0; #1;
    chk("R6 sel0 idle", 32'(tx_irq), 32'd1);

    // R10 width change flushes, flags kept
    for (int k = 0; k < 17; k++) rx_in(32'(k));
    tx_in(32'h11); tx_in(32'h22); tx_in(32'h33);
    chk("R10 pre-flush ovf", 32'(ovf_flag), 32'd1);
    width_sel = 2'd1; step();
    chk("R10 tx flushed on width", 32'(tx_level), 32'd0);
    chk("R10 rx flushed on width", 32'(rx_level), 32'd0);
    chk("R10 flag kept", 32'(ovf_flag), 32'd1);
    step();
    tx_in(32'h44); tx_in(32'h55);
    chk("R10 refill after width", 32'(tx_level), 32'd2);
    enable = 1'b0; step(); enable = 1'b1;
    chk("R10 flushed on disable", 32'(tx_level), 32'd0);
    chk("R10 tx data gone", eng_tx_data, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule